// File: doc/BRIEF.md
# Retire Counter with Compare Timer

The block keeps a 64-bit event counter that moves forward each clock by a small retire count, so it serves as a cycle, time or retired-event counter. Beside it sits a 32-bit compare register. When an advance of the counter carries its low 32 bits from at or below the compare value to at or above it, a timer-pending flag is raised for the interrupt logic. The crossing test covers an advance that jumps past the compare value. An exact-equality test would miss that case.

Software can overwrite the low counter word, the high counter word and the compare register. Writing the compare register clears the pending flag, and this is how a handler acknowledges the timer. A counter write replaces the advance in the same cycle. A read selector gives four aliases of the counter and four aliases of its upper word. In 64-bit mode the upper-word aliases flag an illegal access.

Top module: `cnt_cmp_timer`

## Requirements
- R1: While rst_ni is low, cnt_o is 0, tip_o is 0 and the compare register is 0.
- R2: In a cycle with no counter write, the counter at the next edge is its old value plus inc_i, taken modulo 2^64. A carry out of the low word reaches the high word.
- R3: wr_lo_i replaces bits 31:0 of the counter with wr_data_i and keeps bits 63:32. Any counter write (wr_lo_i or wr_hi_i) discards inc_i for that cycle.
- R4: wr_hi_i replaces bits 63:32 with wr_data_i and keeps bits 31:0.
- R5: tip_o is set at the next edge when all of these hold in a cycle: inc_i is nonzero, there is no counter write and no compare write, the low word L is at or below the compare value C, and L + inc_i, computed as an unwrapped 33-bit sum, is at or above C. This includes advances that step over C and advances that wrap the low word.
- R6: tip_o is not set by an advance that starts with L above C, by a cycle with inc_i = 0 (even when L equals C), or by a cycle that writes the counter.
- R7: Once set, tip_o stays set until a compare write. wr_cmp_i clears tip_o and loads wr_data_i into the compare register at the same edge. In that cycle it overrides any crossing.
- R8: rd_sel_i[2] = 0 selects a full-counter alias. rd_sel_i[1:0] = 0, 1, 2, 3 name the cycle, time, retired and count aliases, and all four return cnt_o on rd_data_o with rd_illegal_o = 0.
- R9: rd_sel_i[2] = 1 selects the upper-word alias of the same four names. With rv64_i = 0 these return {32'b0, cnt_o[63:32]} with rd_illegal_o = 0. With rv64_i = 1 they return 0 with rd_illegal_o = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inc_i | input | 3 | Retire count added this cycle |
| wr_lo_i | input | 1 | Write low counter word |
| wr_hi_i | input | 1 | Write high counter word |
| wr_cmp_i | input | 1 | Write compare register, clears pending timer |
| wr_data_i | input | 32 | Write data shared by all three writes |
| rv64_i | input | 1 | 64-bit mode; upper-word aliases become illegal |
| rd_sel_i | input | 3 | Read alias: bit 2 upper word, bits 1:0 alias name |
| rd_data_o | output | 64 | Read data for the selected alias |
| rd_illegal_o | output | 1 | Selected alias is illegal in this mode |
| cnt_o | output | 64 | Current counter value |
| tip_o | output | 1 | Timer interrupt pending |

## Verification
Three kinds of advance are tried. A steady step of 5 lands exactly on the compare value, which separates the at-or-above test from a strictly-above test. A step of 7 from just below the compare value passes it, which separates the crossing test from an equality test. A step of 3 from 0xFFFFFFFE over a compare value of 0xFFFFFFFF checks that the sum is not truncated to 32 bits. Four negative cases also run: an advance that starts past the compare value, a zero advance sitting on it, a counter write during a would-be crossing, and a compare write during a crossing. They separate the R5 conditions from R6 and R7. The eight read selections are run in both modes.

// File: rtl/cct_pkg.sv
package cct_pkg;
  typedef enum logic [1:0] {
    AL_CYCLE   = 2'd0,
    AL_TIME    = 2'd1,
    AL_RETIRED = 2'd2,
    AL_COUNT   = 2'd3
  } alias_e;

  typedef struct packed {
    logic wr_cmp;
    logic wr_hi;
    logic wr_lo;
  } wr_cmd_t;
endpackage

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int CNT_W = 64,
  parameter int INC_W = 3,
  localparam int LO_W = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  input  cct_pkg::wr_cmd_t cmd_i,
  input  logic [LO_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             adv_o
);
  logic [LO_W-1:0]  half_q [2];
  logic [CNT_W-1:0] sum;
  logic [1:0]       half_we;
  logic             any_wr;

  assign half_we = {cmd_i.wr_hi, cmd_i.wr_lo};
  assign any_wr  = |half_we;
  assign cnt_o   = {half_q[1], half_q[0]};
  assign sum     = cnt_o + CNT_W'(inc_i);
  // advance only counts when no write overrides it
  assign adv_o   = !any_wr && (inc_i != '0);

  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          half_q[h] <= '0;
      else if (any_wr) begin
        if (half_we[h])     half_q[h] <= wr_data_i;
      end else              half_q[h] <= sum[h*LO_W +: LO_W];
    end
  end
endmodule

// File: rtl/cct_cross.sv
module cct_cross #(
  parameter int LO_W  = 32,
  parameter int INC_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LO_W-1:0]  lo_i,
  input  logic [INC_W-1:0] inc_i,
  input  logic             adv_i,
  input  logic             wr_cmp_i,
  input  logic [LO_W-1:0]  wr_data_i,
  output logic             tip_o
);
  logic [LO_W-1:0] cmp_q;
  logic [LO_W:0]   lo_after;
  logic            was_le, now_ge, hit;

  // unwrapped sum so an advance over 2^32 still counts as a crossing
  assign lo_after = {1'b0, lo_i} + (LO_W+1)'(inc_i);
  assign was_le   = lo_i <= cmp_q;
  assign now_ge   = lo_after >= {1'b0, cmp_q};
  assign hit      = adv_i && was_le && now_ge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmp_q <= '0;
      tip_o <= 1'b0;
    end else if (wr_cmp_i) begin
      cmp_q <= wr_data_i;
      tip_o <= 1'b0;
    end else if (hit) begin
      tip_o <= 1'b1;
    end
  end
endmodule

// File: rtl/cct_read.sv
module cct_read #(
  parameter int CNT_W = 64,
  localparam int LO_W = CNT_W / 2
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [2:0]       sel_i,
  input  logic             rv64_i,
  output logic [CNT_W-1:0] data_o,
  output logic             illegal_o
);
  import cct_pkg::*;
  logic [CNT_W-1:0] word;

  always_comb begin
    word = '0;
    unique case (alias_e'(sel_i[1:0]))
      AL_CYCLE, AL_TIME, AL_RETIRED, AL_COUNT:
        word = sel_i[2] ? {{LO_W{1'b0}}, cnt_i[CNT_W-1:LO_W]} : cnt_i;
      default: word = '0;
    endcase
    illegal_o = sel_i[2] && rv64_i;
    data_o    = illegal_o ? '0 : word;
  end
endmodule

// File: rtl/cnt_cmp_timer.sv
module cnt_cmp_timer #(
  parameter int CNT_W = 64,
  parameter int INC_W = 3,
  localparam int LO_W = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [INC_W-1:0] inc_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic             wr_cmp_i,
  input  logic [LO_W-1:0]  wr_data_i,
  input  logic             rv64_i,
  input  logic [2:0]       rd_sel_i,
  output logic [CNT_W-1:0] rd_data_o,
  output logic             rd_illegal_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             tip_o
);
  cct_pkg::wr_cmd_t cmd;
  logic             adv;

  assign cmd = '{wr_cmp: wr_cmp_i, wr_hi: wr_hi_i, wr_lo: wr_lo_i};

  cct_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
    .clk_i, .rst_ni, .inc_i, .cmd_i(cmd), .wr_data_i,
    .cnt_o, .adv_o(adv)
  );

  cct_cross #(.LO_W(LO_W), .INC_W(INC_W)) u_cross (
    .clk_i, .rst_ni, .lo_i(cnt_o[LO_W-1:0]), .inc_i, .adv_i(adv),
    .wr_cmp_i, .wr_data_i, .tip_o
  );

  cct_read #(.CNT_W(CNT_W)) u_rd (
    .cnt_i(cnt_o), .sel_i(rd_sel_i), .rv64_i,
    .data_o(rd_data_o), .illegal_o(rd_illegal_o)
  );
endmodule

// File: rtl/cct_checker.sv
module cct_checker #(
  parameter int CNT_W = 64,
  parameter int INC_W = 3,
  localparam int LO_W = CNT_W / 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [INC_W-1:0] inc_i,
  input logic             wr_lo_i,
  input logic             wr_hi_i,
  input logic             wr_cmp_i,
  input logic [LO_W-1:0]  wr_data_i,
  input logic             rv64_i,
  input logic [2:0]       rd_sel_i,
  input logic [CNT_W-1:0] rd_data_o,
  input logic             rd_illegal_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             tip_o
);
  a_r2_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_lo_i && !wr_hi_i) |=> cnt_o == $past(cnt_o) + CNT_W'($past(inc_i)));

  a_r3_low_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lo_i && !wr_hi_i) |=> (cnt_o[LO_W-1:0] == $past(wr_data_i))
      && (cnt_o[CNT_W-1:LO_W] == $past(cnt_o[CNT_W-1:LO_W])));

  a_r4_high_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hi_i && !wr_lo_i) |=> (cnt_o[CNT_W-1:LO_W] == $past(wr_data_i))
      && (cnt_o[LO_W-1:0] == $past(cnt_o[LO_W-1:0])));

  a_r5_rise_needs_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tip_o) |-> ($past(inc_i) != '0) && !$past(wr_lo_i)
      && !$past(wr_hi_i) && !$past(wr_cmp_i));

  a_r7_cmp_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cmp_i |=> !tip_o);

  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tip_o && !wr_cmp_i) |=> tip_o);

  a_r8_full_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_sel_i[2] |-> (rd_data_o == cnt_o) && !rd_illegal_o);

  a_r9_high_alias: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_sel_i[2] |-> (rv64_i ? (rd_illegal_o && rd_data_o == '0)
      : (!rd_illegal_o && rd_data_o == {{LO_W{1'b0}}, cnt_o[CNT_W-1:LO_W]})));
endmodule

bind cnt_cmp_timer cct_checker #(.CNT_W(CNT_W), .INC_W(INC_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .inc_i(inc_i), .wr_lo_i(wr_lo_i),
  .wr_hi_i(wr_hi_i), .wr_cmp_i(wr_cmp_i), .wr_data_i(wr_data_i),
  .rv64_i(rv64_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o),
  .rd_illegal_o(rd_illegal_o), .cnt_o(cnt_o), .tip_o(tip_o)
);

// File: tb/sim_cnt_cmp_timer.sv
module sim_cnt_cmp_timer;
  localparam int CNT_W = 64;
  localparam int INC_W = 3;
  localparam int LO_W  = 32;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [INC_W-1:0] inc = '0;
  logic             wl = 1'b0, wh = 1'b0, wc = 1'b0, rv64 = 1'b0;
  logic [LO_W-1:0]  wd = '0;
  logic [2:0]       sel = '0;
  logic [CNT_W-1:0] rd_data, cnt;
  logic             rd_ill, tip;

  cnt_cmp_timer #(.CNT_W(CNT_W), .INC_W(INC_W)) u0 (
    .clk_i(clk), .rst_ni, .inc_i(inc), .wr_lo_i(wl), .wr_hi_i(wh),
    .wr_cmp_i(wc), .wr_data_i(wd), .rv64_i(rv64), .rd_sel_i(sel),
    .rd_data_o(rd_data), .rd_illegal_o(rd_ill), .cnt_o(cnt), .tip_o(tip)
  );

  always #4 clk = ~clk;

  typedef struct {
    logic [CNT_W-1:0] cnt;
    logic             tip;
    string            req;
  } exp_t;

  exp_t             q[$];
  int               n_cmp = 0, n_bad = 0;
  logic [CNT_W-1:0] m_cnt = '0;
  logic [LO_W-1:0]  m_cmp = '0;
  logic             m_tip = 1'b0;
  bit               done = 0;

  task automatic chk(input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp,
                     input string req);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // driver: apply one cycle of stimulus, push the expected state after the edge
  task automatic cyc(input logic [INC_W-1:0] i, input logic l, input logic h,
                     input logic c, input logic [LO_W-1:0] d, input string req);
    logic [LO_W-1:0] lo;
    @(negedge clk);
    inc = i; wl = l; wh = h; wc = c; wd = d;
    lo = m_cnt[LO_W-1:0];
    if (c) m_tip = 1'b0;
    else if (!l && !h && i != '0 && lo <= m_cmp &&
             ({1'b0, lo} + 33'(i)) >= {1'b0, m_cmp}) m_tip = 1'b1;
    if (c) m_cmp = d;
    if (l || h) begin
      if (l) m_cnt[LO_W-1:0] = d;
      if (h) m_cnt[CNT_W-1:LO_W] = d;
    end else m_cnt = m_cnt + CNT_W'(i);
    q.push_back('{m_cnt, m_tip, req});
  endtask

  task automatic idle();
    @(negedge clk);
    inc = '0; wl = 0; wh = 0; wc = 0;
  endtask

  task automatic rd(input logic [2:0] s, input logic m, input string req);
    logic [CNT_W-1:0] e;
    idle();
    sel = s; rv64 = m;
    #1;
    e = (s[2] && m) ? '0 : (s[2] ? {32'b0, m_cnt[CNT_W-1:LO_W]} : m_cnt);
    chk(rd_data, e, req);
    chk({63'b0, rd_ill}, {63'b0, s[2] & m}, req);
  endtask

  // monitor
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(cnt, e.cnt, {e.req, " cnt"});
      chk({63'b0, tip}, {63'b0, e.tip}, {e.req, " tip"});
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #21;
    chk(cnt, '0, "R1 reset cnt");
    chk({63'b0, tip}, '0, "R1 reset tip");
    @(negedge clk); rst_ni = 1'b1;

    cyc(0, 0, 0, 1, 32'd100, "R7 load cmp");
    // R5: steady steps of 5 land exactly on 100
    for (int k = 0; k < 22; k++) cyc(5, 0, 0, 0, 0, "R5 step on");
    cyc(1, 0, 0, 0, 0, "R7 sticky");
    cyc(0, 0, 0, 1, 32'd200, "R7 clear");
    // R5 jump over: 198 + 7 = 205 crosses 200
    cyc(0, 1, 0, 0, 32'd198, "R3 low write");
    cyc(7, 0, 0, 0, 0, "R5 jump over");
    cyc(0, 0, 0, 1, 32'd210, "R7 clear2");
    // R7: compare write wins over a crossing 205->212 of 210
    cyc(7, 0, 0, 1, 32'd300, "R7 cmp vs cross");
    // R6: start past compare
    cyc(0, 1, 0, 0, 32'd301, "R3 low write2");
    cyc(7, 0, 0, 0, 0, "R6 past cmp");
    // R6/R3: counter write blocks crossing and drops inc
    cyc(0, 1, 0, 0, 32'd295, "R3 low write3");
    cyc(7, 1, 0, 0, 32'd299, "R3 write over inc");
    cyc(0, 1, 0, 0, 32'd300, "R3 low write4");
    cyc(0, 0, 0, 0, 0, "R6 zero inc on cmp");
    // R4 then carry and low-word wrap crossing
    cyc(0, 0, 1, 0, 32'h1234_5678, "R4 high write");
    cyc(0, 1, 0, 0, 32'hFFFF_FFFE, "R3 low write5");
    cyc(0, 0, 0, 1, 32'hFFFF_FFFF, "R7 cmp max");
    cyc(3, 0, 0, 0, 0, "R5 wrap cross R2 carry");
    for (int s = 0; s < 8; s++) rd(3'(s), 1'b0, s < 4 ? "R8 alias" : "R9 hi rv32");
    for (int s = 0; s < 8; s++) rd(3'(s), 1'b1, s < 4 ? "R8 alias rv64" : "R9 hi rv64");
    cyc(0, 1, 1, 0, 32'hFFFF_FFFF, "R3 R4 both");
    cyc(1, 0, 0, 0, 0, "R2 64-bit wrap");
    idle(); idle();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule